// File: doc/BRIEF.md
# Bus-Limited Group Permutation Unit

This block reorders the elements of a group register. A group register holds one element per slice, and there are `NSLICE` slices. For each destination slice, the caller supplies a source slice index and a valid bit. A single start strobe then launches the operation. The unit writes the rearranged group into its output register, raises a one-cycle done flag, and keeps busy high for as long as the operation runs.

There are two ways an element can travel. A destination that takes its own element, or an element from the slice directly beside it, uses a neighbour path that costs no shared resource. Every other move goes over a global crossbar that has `NBUS` shared buses, and each bus carries one element per cycle. These global moves are served lowest destination first, in batches of at most `NBUS` per cycle. A smaller bus count therefore saves crossbar area and costs extra cycles. A request where every destination picks the same source is recognised as a broadcast, and it drives all slices from one bus in a single cycle.

The result becomes visible all at once, on the cycle the last batch lands. New starts are refused until then.

Top module: `gperm_unit`

## Requirements
- R1: After reset, the output group is all zeros, and done and busy are both low.
- R2: A start that arrives while busy is high has no effect. The running operation's result and cycle count are unchanged.
- R3: A destination whose valid bit is 0 keeps the value its output register held before the operation.
- R4: A valid destination whose source index equals its own index, or differs from it by exactly one (no wrap-around), receives the element at that source index by the neighbour path and uses no bus.
- R5: Every other valid destination receives the element at its selected source index through the global crossbar.
- R6: Global moves are granted in ascending destination order, at most NBUS per cycle. Busy stays high for max(1, ceil(global moves / NBUS)) cycles after the start edge.
- R7: A start with all valid bits set and every source index equal is a broadcast. Every destination gets that source's element, and busy lasts exactly one cycle.
- R8: The output group changes only on the edge that raises done. Done is high for one cycle, and busy is low in that cycle.
- R9: The source group and the select vector are captured at the accepted start. Changes on those inputs while busy is high do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches an operation when busy is low |
| src_group_i | input | NSLICE*EW | Source group; slice d occupies bits d*EW upward |
| sel_idx_i | input | NSLICE*SW | Source slice index for each destination; destination d occupies bits d*SW upward |
| sel_vld_i | input | NSLICE | Valid bit for each destination's select |
| group_o | output | NSLICE*EW | Permuted destination group register |
| done_o | output | 1 | One-cycle pulse when the result is written |
| busy_o | output | 1 | High while an operation is in progress |

## Verification
The hardest case to reach from the ports is a start that arrives while a long, bus-starved operation is still running. To test it, the bench first launches a full reversal, which needs several batches on the two-bus variant. It then changes the source, the selects and the start strobe in the cycle after acceptance, and checks that the result and the cycle count still match the first request. The same stimulus drives three copies of the unit, with 2, 4 and 8 buses. For each copy, the bench compares the exact completion cycle against its own model of how many moves stay local and how many need a bus. Near-broadcasts, with one select differing, are mixed in so that broadcast detection has to tell them apart from true broadcasts.

// File: rtl/gperm_pkg.sv
package gperm_pkg;

    // How a destination slice obtains its new element.
    typedef enum logic [1:0] {
        ROUTE_KEEP   = 2'd0,
        ROUTE_LOCAL  = 2'd1,
        ROUTE_GLOBAL = 2'd2
    } route_e;

endpackage

// File: rtl/gperm_route_class.sv
// Classifies each destination and supplies the neighbour-path data.
module gperm_route_class
    import gperm_pkg::*;
#(
    parameter int NSLICE = 16,
    parameter int EW     = 16,
    localparam int SW    = $clog2(NSLICE)
) (
    input  logic [NSLICE-1:0][EW-1:0] src_i,
    input  logic [NSLICE-1:0][SW-1:0] sel_i,
    input  logic [NSLICE-1:0]         vld_i,
    output logic [NSLICE-1:0]         loc_mask_o,
    output logic [NSLICE-1:0]         glob_mask_o,
    output logic [NSLICE-1:0][EW-1:0] loc_data_o,
    output logic                      bcast_o
);

    route_e route [NSLICE];

    // Neighbour path: each slice sees only itself and its two neighbours.
    for (genvar d = 0; d < NSLICE; d++) begin : g_slice
        logic [EW-1:0] left_w;
        logic [EW-1:0] right_w;
        if (d > 0) begin : g_left
            assign left_w = src_i[d-1];
        end else begin : g_noleft
            assign left_w = '0;
        end
        if (d < NSLICE - 1) begin : g_right
            assign right_w = src_i[d+1];
        end else begin : g_noright
            assign right_w = '0;
        end

        always_comb begin
            int s;
            s = int'(sel_i[d]);
            if (!vld_i[d]) begin
                route[d] = ROUTE_KEEP;
            end else if (s == d || s == d - 1 || s == d + 1) begin
                route[d] = ROUTE_LOCAL;
            end else begin
                route[d] = ROUTE_GLOBAL;
            end
            if (s == d - 1) begin
                loc_data_o[d] = left_w;
            end else if (s == d + 1) begin
                loc_data_o[d] = right_w;
            end else begin
                loc_data_o[d] = src_i[d];
            end
        end

        assign loc_mask_o[d]  = (route[d] == ROUTE_LOCAL);
        assign glob_mask_o[d] = (route[d] == ROUTE_GLOBAL);
    end

    // Broadcast: every destination valid and naming the same source.
    always_comb begin
        bcast_o = &vld_i;
        for (int d = 1; d < NSLICE; d++) begin
            if (sel_i[d] != sel_i[0]) begin
                bcast_o = 1'b0;
            end
        end
    end

endmodule

// File: rtl/gperm_bus_arb.sv
// Grants up to NBUS pending destinations per cycle, lowest index first.
module gperm_bus_arb #(
    parameter int NSLICE = 16,
    parameter int NBUS   = 4,
    localparam int SW    = $clog2(NSLICE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSLICE-1:0]       req_i,
    output logic [NSLICE-1:0]       grant_o,
    output logic [NBUS-1:0]         bus_vld_o,
    output logic [NBUS-1:0][SW-1:0] bus_dst_o
);

    always_comb begin
        logic [NSLICE-1:0] rem;
        rem       = req_i;
        grant_o   = '0;
        bus_vld_o = '0;
        bus_dst_o = '0;
        for (int b = 0; b < NBUS; b++) begin
            logic hit;
            hit = 1'b0;
            for (int d = 0; d < NSLICE; d++) begin
                if (rem[d] && !hit) begin
                    hit          = 1'b1;
                    bus_dst_o[b] = SW'(d);
                end
            end
            if (hit) begin
                bus_vld_o[b]          = 1'b1;
                rem[bus_dst_o[b]]     = 1'b0;
                grant_o[bus_dst_o[b]] = 1'b1;
            end
        end
    end

    // R6: never more grants than buses.
    p_bus_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) <= NBUS);

    // R6: only pending destinations are granted.
    p_grant_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

    // R6: a batch that leaves a bus idle must have taken every request.
    p_batch_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(grant_o) < NBUS) |-> (grant_o == req_i));

endmodule

// File: rtl/gperm_bus_xbar.sv
// Shared-bus crossbar: each bus picks one source element and delivers it
// to one destination, or bus 0 feeds every slice in broadcast mode.
module gperm_bus_xbar #(
    parameter int NSLICE = 16,
    parameter int EW     = 16,
    parameter int NBUS   = 4,
    localparam int SW    = $clog2(NSLICE)
) (
    input  logic [NSLICE-1:0][EW-1:0] src_i,
    input  logic [NSLICE-1:0][SW-1:0] sel_i,
    input  logic [NBUS-1:0]           bus_vld_i,
    input  logic [NBUS-1:0][SW-1:0]   bus_dst_i,
    input  logic                      bcast_i,
    input  logic [SW-1:0]             bcast_src_i,
    output logic [NSLICE-1:0]         wr_o,
    output logic [NSLICE-1:0][EW-1:0] wr_data_o
);

    logic [NBUS-1:0][EW-1:0] bus_data;

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        if (b == 0) begin : g_bus0
            assign bus_data[b] = bcast_i ? src_i[bcast_src_i]
                                         : src_i[sel_i[bus_dst_i[b]]];
        end else begin : g_busn
            assign bus_data[b] = src_i[sel_i[bus_dst_i[b]]];
        end
    end

    always_comb begin
        wr_o      = '0;
        wr_data_o = '0;
        for (int d = 0; d < NSLICE; d++) begin
            if (bcast_i) begin
                wr_o[d]      = 1'b1;
                wr_data_o[d] = bus_data[0];
            end else begin
                for (int b = 0; b < NBUS; b++) begin
                    if (bus_vld_i[b] && int'(bus_dst_i[b]) == d) begin
                        wr_o[d]      = 1'b1;
                        wr_data_o[d] = bus_data[b];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gperm_unit.sv
module gperm_unit #(
    parameter int NSLICE = 16,   // power of two
    parameter int EW     = 16,
    parameter int NBUS   = 4,    // 1 .. NSLICE
    localparam int SW    = $clog2(NSLICE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NSLICE*EW-1:0] src_group_i,
    input  logic [NSLICE*SW-1:0] sel_idx_i,
    input  logic [NSLICE-1:0]    sel_vld_i,
    output logic [NSLICE*EW-1:0] group_o,
    output logic                 done_o,
    output logic                 busy_o
);

    typedef struct packed {
        logic                      busy;
        logic                      done;
        logic                      bcast;
        logic [SW-1:0]             bsrc;
        logic [NSLICE-1:0]         pend;
        logic [NSLICE-1:0][EW-1:0] src;
        logic [NSLICE-1:0][SW-1:0] sel;
        logic [NSLICE-1:0][EW-1:0] stage;
        logic [NSLICE-1:0][EW-1:0] out;
    } state_t;

    state_t q, n;

    logic [NSLICE-1:0][EW-1:0] src_w;
    logic [NSLICE-1:0][SW-1:0] sel_w;
    logic [NSLICE-1:0]         loc_mask_w;
    logic [NSLICE-1:0]         glob_mask_w;
    logic [NSLICE-1:0][EW-1:0] loc_data_w;
    logic                      bcast_w;
    logic [NSLICE-1:0]         grant_w;
    logic [NBUS-1:0]           bus_vld_w;
    logic [NBUS-1:0][SW-1:0]   bus_dst_w;
    logic [NSLICE-1:0]         wr_w;
    logic [NSLICE-1:0][EW-1:0] wr_data_w;
    logic                      accept_w;

    assign src_w = src_group_i;
    assign sel_w = sel_idx_i;

    gperm_route_class #(.NSLICE(NSLICE), .EW(EW)) u_class (
        .src_i       (src_w),
        .sel_i       (sel_w),
        .vld_i       (sel_vld_i),
        .loc_mask_o  (loc_mask_w),
        .glob_mask_o (glob_mask_w),
        .loc_data_o  (loc_data_w),
        .bcast_o     (bcast_w)
    );

    gperm_bus_arb #(.NSLICE(NSLICE), .NBUS(NBUS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (q.busy ? q.pend : '0),
        .grant_o   (grant_w),
        .bus_vld_o (bus_vld_w),
        .bus_dst_o (bus_dst_w)
    );

    gperm_bus_xbar #(.NSLICE(NSLICE), .EW(EW), .NBUS(NBUS)) u_xbar (
        .src_i       (q.src),
        .sel_i       (q.sel),
        .bus_vld_i   (bus_vld_w),
        .bus_dst_i   (bus_dst_w),
        .bcast_i     (q.busy && q.bcast),
        .bcast_src_i (q.bsrc),
        .wr_o        (wr_w),
        .wr_data_o   (wr_data_w)
    );

    assign accept_w = start_i && !q.busy;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (accept_w) begin
            n.busy  = 1'b1;
            n.src   = src_w;
            n.sel   = sel_w;
            n.bcast = bcast_w;
            n.bsrc  = sel_w[0];
            n.pend  = bcast_w ? '0 : glob_mask_w;
            for (int d = 0; d < NSLICE; d++) begin
                n.stage[d] = loc_mask_w[d] ? loc_data_w[d] : q.out[d];
            end
        end else if (q.busy) begin
            for (int d = 0; d < NSLICE; d++) begin
                if (wr_w[d]) begin
                    n.stage[d] = wr_data_w[d];
                end
            end
            n.pend = q.pend & ~grant_w;
            if (n.pend == '0) begin
                n.busy  = 1'b0;
                n.done  = 1'b1;
                n.bcast = 1'b0;
                n.out   = n.stage;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign group_o = q.out;
    assign done_o  = q.done;
    assign busy_o  = q.busy;

    // R8: the result register moves only together with done.
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(group_o));

    // R8: done is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done never coincides with busy.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R2, R9: captured request is untouched while busy.
    p_busy_ignore_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(q.sel) && $stable(q.src)));

    // R7: an accepted broadcast completes after one busy cycle.
    p_bcast_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && bcast_w) |=> (busy_o ##1 done_o));

endmodule

// File: tb/gperm_unit_tb.sv
module gperm_unit_tb_top;

    localparam int P  = 16;
    localparam int EW = 16;
    localparam int SW = $clog2(P);
    localparam int NK = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [P*EW-1:0] src_group_i = '0;
    logic [P*SW-1:0] sel_idx_i = '0;
    logic [P-1:0]    sel_vld_i = '0;

    logic [P*EW-1:0] group_o [NK];
    logic            done_o  [NK];
    logic            busy_o  [NK];

    int checks = 0;
    int errors = 0;
    int cycle_ctr = 0;

    int elem_a [P];
    int sel_a  [P];
    int vld_a  [P];
    int model_out [P];
    int exp_cyc [NK];

    always #4 clk = ~clk;   // 125 MHz

    for (genvar k = 0; k < NK; k++) begin : g_dut
        gperm_unit #(.NSLICE(P), .EW(EW), .NBUS(2 << k)) dut_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_i     (start_i),
            .src_group_i (src_group_i),
            .sel_idx_i   (sel_idx_i),
            .sel_vld_i   (sel_vld_i),
            .group_o     (group_o[k]),
            .done_o      (done_o[k]),
            .busy_o      (busy_o[k])
        );
    end

    always @(posedge clk) begin
        cycle_ctr <= cycle_ctr + 1;
        if (cycle_ctr > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles, expected < 100000", cycle_ctr);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model of R3..R7: compute the next output and cycles per bus count.
    task automatic compute_model();
        int moves;
        int bc;
        int nxt [P];
        bc = 1;
        for (int d = 0; d < P; d++) begin
            if (vld_a[d] == 0 || sel_a[d] != sel_a[0]) bc = 0;
        end
        moves = 0;
        for (int d = 0; d < P; d++) begin
            nxt[d] = model_out[d];
            if (vld_a[d] != 0) begin
                nxt[d] = elem_a[sel_a[d]];
                if (!(sel_a[d] == d || sel_a[d] == d - 1 || sel_a[d] == d + 1))
                    moves++;
            end
        end
        for (int d = 0; d < P; d++) model_out[d] = nxt[d];
        for (int k = 0; k < NK; k++) begin
            int b;
            b = 2 << k;
            if (bc != 0) exp_cyc[k] = 1;
            else exp_cyc[k] = (moves == 0) ? 1 : (moves + b - 1) / b;
        end
    endtask

    task automatic drive_inputs();
        for (int d = 0; d < P; d++) begin
            src_group_i[d*EW +: EW] = EW'(elem_a[d]);
            sel_idx_i[d*SW +: SW]   = SW'(sel_a[d]);
            sel_vld_i[d]            = (vld_a[d] != 0);
        end
    endtask

    // Runs one operation on all three units; inject=1 disturbs the inputs
    // and pulses start again while the units are busy (R2, R9).
    task automatic run_op(input string req, input int inject);
        int seen [NK];
        int got  [NK];
        compute_model();
        @(negedge clk);
        drive_inputs();
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        if (inject != 0) begin
            start_i = 1'b1;
            for (int d = 0; d < P; d++) begin
                src_group_i[d*EW +: EW] = EW'(16'hdead ^ d);
                sel_idx_i[d*SW +: SW]   = SW'(P - 1 - d);
            end
            sel_vld_i = '1;
        end
        for (int k = 0; k < NK; k++) begin
            seen[k] = 0;
            got[k]  = -1;
        end
        for (int c = 1; c <= 40; c++) begin
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            for (int k = 0; k < NK; k++) begin
                if (seen[k] == 0 && done_o[k]) begin
                    seen[k] = 1;
                    got[k]  = c;
                end
            end
            if (seen[0] != 0 && seen[1] != 0 && seen[2] != 0) break;
        end
        for (int k = 0; k < NK; k++) begin
            check({req, " R6 cycles"}, got[k], exp_cyc[k]);
            for (int d = 0; d < P; d++) begin
                check({req, " R5 data"}, int'(group_o[k][d*EW +: EW]), model_out[d]);
            end
            check({req, " R8 busy low at done"}, int'(busy_o[k]), 0);
        end
    endtask

    task automatic fill_elems(input int base);
        for (int d = 0; d < P; d++) elem_a[d] = (base + d * 37) & 16'hffff;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int d = 0; d < P; d++) model_out[d] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        for (int k = 0; k < NK; k++) begin
            check("R1 group zero", (group_o[k] == '0) ? 1 : 0, 1);
            check("R1 done low", int'(done_o[k]), 0);
            check("R1 busy low", int'(busy_o[k]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R4: identity, all local
        fill_elems(100);
        for (int d = 0; d < P; d++) begin sel_a[d] = d; vld_a[d] = 1; end
        run_op("R4 identity", 0);

        // R4: shift by one, local path, including both edges
        fill_elems(7);
        for (int d = 0; d < P; d++) begin sel_a[d] = (d == 0) ? 1 : d - 1; vld_a[d] = 1; end
        run_op("R4 shift", 0);

        // R5/R6: full reversal, 14 global moves
        fill_elems(900);
        for (int d = 0; d < P; d++) begin sel_a[d] = P - 1 - d; vld_a[d] = 1; end
        run_op("R6 reverse", 0);

        // R2/R9: reversal again with disturbance while busy
        fill_elems(4321);
        for (int d = 0; d < P; d++) begin sel_a[d] = P - 1 - d; vld_a[d] = 1; end
        run_op("R2 R9 busy start", 1);

        // R7: broadcast from slice 5
        fill_elems(55);
        for (int d = 0; d < P; d++) begin sel_a[d] = 5; vld_a[d] = 1; end
        run_op("R7 broadcast", 0);

        // R7 boundary: near-broadcast, one destination differs
        fill_elems(333);
        for (int d = 0; d < P; d++) begin sel_a[d] = 12; vld_a[d] = 1; end
        sel_a[0] = 3;
        run_op("R7 near broadcast", 0);

        // R3: invalid destinations keep their old value
        fill_elems(2000);
        for (int d = 0; d < P; d++) begin sel_a[d] = (d * 5) % P; vld_a[d] = d % 3; end
        run_op("R3 partial valid", 0);

        // R3/R6: nothing valid, one cycle, no change
        fill_elems(8000);
        for (int d = 0; d < P; d++) begin sel_a[d] = 0; vld_a[d] = 0; end
        run_op("R3 none valid", 0);

        // Random permutations and selects
        for (int t = 0; t < 40; t++) begin
            fill_elems(int'($urandom_range(0, 65535)));
            for (int d = 0; d < P; d++) begin
                sel_a[d] = int'($urandom_range(0, P - 1));
                vld_a[d] = ($urandom_range(0, 7) != 0) ? 1 : 0;
            end
            if (t % 4 == 0) begin
                for (int d = 0; d < P; d++) sel_a[d] = d;
                for (int d = P - 1; d > 0; d--) begin
                    int j;
                    int tmp;
                    j = int'($urandom_range(0, d));
                    tmp = sel_a[d]; sel_a[d] = sel_a[j]; sel_a[j] = tmp;
                end
            end
            run_op("R5 R6 random", (t % 10 == 9) ? 1 : 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule